// File: doc/BRIEF.md
# Shortened Fire Code Frame Encoder

This block sits in a high-speed Ethernet transmit path, after the 64b/66b coder. It turns a continuous stream of 66-bit line words into protected frames. Every group of 32 consecutive input words forms one frame. Each word is cut from 66 to 65 bits: of its two-bit sync header, only the second bit is kept. The 2080 payload bits that result are followed by a 32-bit cyclic check. The check is the remainder over the generator x^32 + x^23 + x^21 + x^11 + x^2 + 1.

The 2112-bit coded frame is XORed with a pseudo-noise sequence from the generator x^58 + x^39 + 1. That sequence restarts from a fixed nonzero seed at each frame. The result leaves the block as 32 words of 66 bits. One word is accepted on every clock and one word leaves on every clock. The check bits fill the tail of the last output word, so the output stream needs no idle cycles.

The input carries only a frame-start marker. It has no valid or ready signal. After the first marker, the word index counts on its own and wraps from 31 to 0, so later markers are optional. A marker that arrives in the middle of a frame realigns the stream.

Top module: `fce_encoder`

## Requirements
- R1: After reset, out_valid, out_sof and out_word are all zero. Whenever out_valid is low, out_word and out_sof are zero.
- R2: Payload bit 65i of frame word i is in_word[1]. For j = 1..64, payload bit 65i+j is in_word[j+1]. in_word[0] is discarded.
- R3: Output word k (k = 0..31) carries coded-frame bits 66k..66k+65, with frame bit 66k+j on out_word[j]. out_sof is high exactly with word 0.
- R4: Frame bits 2080..2111 hold the remainder of P(x)·x^32 divided by x^32+x^23+x^21+x^11+x^2+1. P has payload bit 0 as its highest-degree coefficient. Frame bit 2080+q is the coefficient of x^(31-q). The division starts fresh for every frame.
- R5: Line bit n of a frame equals coded bit n XOR s[n]. Here s[0..57] = PN_SEED bits 0..57 and s[n] = s[n-58] XOR s[n-39]. The sequence restarts at bit 0 for every frame.
- R6: Output word k is registered on the clock edge that captures input word k+1 of the same frame. Word 31 is registered on the edge that captures the next frame's word 0. out_sof is therefore high two cycles after the marked word, provided that the following word is unmarked.
- R7: After the first frame start, the word index wraps from 31 to 0 without a new in_sof. Frames then follow back to back with out_valid high on every cycle.
- R8: Until the first in_sof after reset, input words are ignored and out_valid stays low.
- R9: An in_sof on a word whose running index is not 0 abandons the partial frame. The remaining words of that frame are never sent, and out_valid is low for one cycle. The marked word becomes word 0 of a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one line word per rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_word | input | 66 | Input line word; bits 1:0 are the sync header |
| in_sof | input | 1 | Marks the word as word 0 of a frame |
| out_word | output | 66 | Scrambled coded-frame word |
| out_valid | output | 1 | out_word carries a frame word |
| out_sof | output | 1 | out_word is word 0 of a frame |

## Verification
The assertions check these properties on every cycle:
- the outputs are quiet while out_valid is low;
- no output appears before the first frame start;
- out_valid stays high once streaming, unless in_sof interrupts a frame;
- the frame marker reaches the output two cycles after the marked input;
- no frame exceeds 32 output words;
- the scrambler state never falls to zero.

The bit-level content can only be shown by the bench's scenarios, which compare against a bit-serial model. That content covers the header compression, the word packing, the check bits of full frames, the reload of the scrambler sequence, and the words lost at an early restart. Those scenarios include all-zero and all-one payloads, random data with both header values, and frames that rely on index wrap.

// File: rtl/fce_pkg.sv
package fce_pkg;
  localparam int unsigned LINE_W      = 66;
  localparam int unsigned PLD_W       = LINE_W - 1;
  localparam int unsigned FRAME_WORDS = 32;
  localparam int unsigned IDX_W       = $clog2(FRAME_WORDS);
  localparam int unsigned CHK_W       = 32;
  localparam logic [CHK_W-1:0] CHK_POLY = 32'h00A0_0805;
  localparam int unsigned TAIL_W      = LINE_W - CHK_W;
  localparam int unsigned PN_W        = 58;
  localparam int unsigned PN_TAP      = 39;
  localparam int unsigned PN_RUN_W    = PN_W + LINE_W;
  localparam int unsigned JOIN_W      = PLD_W + LINE_W;
  localparam int unsigned SH_W        = $clog2(JOIN_W);

  typedef logic [LINE_W-1:0]   line_t;
  typedef logic [PLD_W-1:0]    pld_t;
  typedef logic [CHK_W-1:0]    chk_t;
  typedef logic [PN_W-1:0]     pn_t;
  typedef logic [PN_RUN_W-1:0] pn_run_t;

  // Keep the second sync bit as the leading payload bit, then the 64 data bits.
  function automatic pld_t squeeze(input line_t w);
    return {w[LINE_W-1:2], w[1]};
  endfunction

  // Shift a whole payload word into the divider, lowest index first.
  function automatic chk_t chk_absorb(input chk_t c_in, input pld_t d);
    chk_t c;
    logic fb;
    c = c_in;
    for (int j = 0; j < PLD_W; j++) begin
      fb = d[j] ^ c[CHK_W-1];
      c  = {c[CHK_W-2:0], 1'b0} ^ (fb ? CHK_POLY : '0);
    end
    return c;
  endfunction

  // Highest remainder coefficient goes out first on the line.
  function automatic chk_t chk_line_order(input chk_t c);
    chk_t r;
    for (int q = 0; q < CHK_W; q++) r[q] = c[CHK_W-1-q];
    return r;
  endfunction

  // Window s[m..m+PN_RUN_W-1] of the sequence, given s[m..m+PN_W-1].
  function automatic pn_run_t pn_run(input pn_t st);
    pn_run_t s;
    s = '0;
    s[PN_W-1:0] = st;
    for (int n = PN_W; n < PN_RUN_W; n++) s[n] = s[n-PN_W] ^ s[n-PN_TAP];
    return s;
  endfunction
endpackage

// File: rtl/fce_frame_seq.sv
module fce_frame_seq
  import fce_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_sof,
  output logic [IDX_W-1:0] cur_idx,
  output logic             active,
  output logic             emit,
  output logic             emit_first,
  output logic             emit_last
);
  logic [IDX_W-1:0] cnt_q;
  logic             started_q;
  logic             full_q;

  assign active     = in_sof | started_q;
  assign cur_idx    = in_sof ? '0 : cnt_q;
  assign emit_last  = active && (cur_idx == '0) && full_q;
  assign emit_first = active && (cur_idx == IDX_W'(1));
  assign emit       = emit_last | (active && (cur_idx != '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      started_q <= 1'b0;
      full_q    <= 1'b0;
    end else begin
      cnt_q     <= active ? cur_idx + IDX_W'(1) : '0;
      started_q <= started_q | in_sof;
      full_q    <= active && (cur_idx == IDX_W'(FRAME_WORDS - 1));
    end
  end
endmodule

// File: rtl/fce_check_gen.sv
module fce_check_gen
  import fce_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic frame_start,
  input  pld_t pld,
  output chk_t chk_q
);
  chk_t base;
  assign base = frame_start ? '0 : chk_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      chk_q <= '0;
    else if (active) chk_q <= chk_absorb(base, pld);
  end
endmodule

// File: rtl/fce_pn_out.sv
module fce_pn_out
  import fce_pkg::*;
#(
  parameter logic [PN_W-1:0] PN_SEED = 58'h2CE_1357_9BDF_2468
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  emit,
  input  logic  emit_first,
  input  line_t plain,
  output line_t out_word,
  output logic  out_valid,
  output logic  out_sof,
  output pn_t   pn_state
);
  pn_t     src;
  pn_run_t run;

  assign src = emit_first ? PN_SEED : pn_state;
  assign run = pn_run(src);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pn_state  <= PN_SEED;
      out_word  <= '0;
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
    end else begin
      if (emit) pn_state <= run[PN_RUN_W-1:LINE_W];
      out_word  <= emit ? (plain ^ run[LINE_W-1:0]) : '0;
      out_valid <= emit;
      out_sof   <= emit_first;
    end
  end
endmodule

// File: rtl/fce_encoder.sv
module fce_encoder
  import fce_pkg::*;
#(
  parameter logic [PN_W-1:0] PN_SEED = 58'h2CE_1357_9BDF_2468
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] in_word,
  input  logic              in_sof,
  output logic [LINE_W-1:0] out_word,
  output logic              out_valid,
  output logic              out_sof
);
  logic [IDX_W-1:0] cur_idx;
  logic             active, emit, emit_first, emit_last;
  pld_t             pld;
  chk_t             chk_q;
  pn_t              pn_state;
  pld_t             pend_q;
  logic [SH_W-1:0]  fill;
  logic [JOIN_W-1:0] joined;
  line_t            plain;

  assign pld = squeeze(in_word);

  fce_frame_seq u_seq (
    .clk(clk), .rst_n(rst_n), .in_sof(in_sof), .cur_idx(cur_idx),
    .active(active), .emit(emit), .emit_first(emit_first), .emit_last(emit_last)
  );

  fce_check_gen u_chk_gen (
    .clk(clk), .rst_n(rst_n), .active(active),
    .frame_start(cur_idx == '0), .pld(pld), .chk_q(chk_q)
  );

  // Pending payload bits: (LINE_W - idx) of them before word idx >= 1.
  assign fill   = SH_W'(LINE_W) - SH_W'(cur_idx);
  assign joined = {{LINE_W{1'b0}}, pend_q} | ({{LINE_W{1'b0}}, pld} << fill);
  assign plain  = emit_last ? {chk_line_order(chk_q), pend_q[TAIL_W-1:0]}
                            : joined[LINE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)      pend_q <= '0;
    else if (active) pend_q <= (cur_idx == '0) ? pld : joined[JOIN_W-1:LINE_W];
  end

  fce_pn_out #(.PN_SEED(PN_SEED)) u_pn (
    .clk(clk), .rst_n(rst_n), .emit(emit), .emit_first(emit_first),
    .plain(plain), .out_word(out_word), .out_valid(out_valid),
    .out_sof(out_sof), .pn_state(pn_state)
  );
endmodule

// File: rtl/fce_encoder_chk.sv
module fce_encoder_chk
  import fce_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        in_sof,
  input logic [LINE_W-1:0] out_word,
  input logic        out_valid,
  input logic        out_sof,
  input logic [PN_W-1:0] pn_state
);
  logic       up_q;
  logic       seen_q;
  logic [6:0] ocnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_q   <= 1'b0;
      seen_q <= 1'b0;
      ocnt_q <= '0;
    end else begin
      up_q   <= 1'b1;
      seen_q <= seen_q | in_sof;
      if (out_valid) ocnt_q <= out_sof ? 7'd1 : ((ocnt_q == 7'h7F) ? ocnt_q : ocnt_q + 7'd1);
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_word == '0 && !out_sof));

  a_r8_quiet_until_start: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> !out_valid);

  a_r7_stream_on: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !in_sof) |=> out_valid);

  a_r6_sof_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && !in_sof && $past(in_sof)) |=> out_sof);

  a_r3_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sof) |-> (ocnt_q < 7'(FRAME_WORDS)));

  a_r5_pn_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    pn_state != '0);
endmodule

bind fce_encoder fce_encoder_chk u_fce_chk (
  .clk(clk), .rst_n(rst_n), .in_sof(in_sof), .out_word(out_word),
  .out_valid(out_valid), .out_sof(out_sof), .pn_state(pn_state)
);

// File: tb/sim_fce_encoder.sv
module sim_fce_encoder;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int NW = 32;
  localparam int FB = 2112;
  localparam logic [57:0] SEED = 58'h2CE_1357_9BDF_2468;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [65:0] in_word = '0;
  logic        in_sof = 1'b0;
  logic [65:0] out_word;
  logic        out_valid, out_sof;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fce_encoder u0 (
    .clk(clk), .rst_n(rst_n), .in_word(in_word), .in_sof(in_sof),
    .out_word(out_word), .out_valid(out_valid), .out_sof(out_sof)
  );

  logic [FB-1:0] pn_seq;
  logic [65:0]   mw [NW];
  bit            m_started = 0, m_full = 0;
  int            m_idx = 0;
  bit            exp_valid = 0, exp_sof = 0;
  logic [65:0]   exp_word = '0;
  string         exp_tag = "R1 R8";

  // Serial reference of one frame from the words in mw (unseen words are zero).
  function automatic logic [FB-1:0] ref_frame();
    logic [FB-1:0] fr;
    logic [31:0] rem;
    logic b;
    int n;
    fr = '0;
    rem = '0;
    for (int i = 0; i < NW; i++)
      for (int j = 0; j < 65; j++) begin
        n = 65*i + j;
        b = (j == 0) ? mw[i][1] : mw[i][j+1];
        fr[n] = b;
        if (b ^ rem[31]) rem = (rem << 1) ^ 32'h00A0_0805;
        else             rem = rem << 1;
      end
    for (int q = 0; q < 32; q++) fr[2080+q] = rem[31-q];
    return fr ^ pn_seq;
  endfunction

  task automatic model(input logic [65:0] w, input bit s);
    int cur;
    logic [FB-1:0] fr;
    exp_valid = 0; exp_sof = 0; exp_word = '0; exp_tag = "R1 R8";
    if (!s && !m_started) return;
    cur = s ? 0 : m_idx;
    if (cur == 0) begin
      if (m_full) begin
        fr = ref_frame();
        exp_valid = 1; exp_word = fr[66*31 +: 66]; exp_tag = "R4 R5 R6 R7";
      end else if (m_started) exp_tag = "R9";
      else exp_tag = "R6";
      for (int k = 0; k < NW; k++) mw[k] = '0;
    end
    mw[cur] = w;
    if (cur != 0) begin
      fr = ref_frame();
      exp_valid = 1; exp_word = fr[66*(cur-1) +: 66];
      exp_sof = (cur == 1);
      exp_tag = (cur == 1) ? "R2 R3 R5 R6" : "R2 R3 R5 R7";
    end
    m_full = (cur == NW-1);
    m_idx = (cur + 1) % NW;
    m_started = 1;
  endtask

  task automatic compare();
    checks++;
    if (out_valid !== exp_valid || out_sof !== exp_sof || out_word !== exp_word) begin
      errors++;
      $display("FAIL %s: valid=%0b sof=%0b word=%h expected valid=%0b sof=%0b word=%h",
               exp_tag, out_valid, out_sof, out_word, exp_valid, exp_sof, exp_word);
    end
  endtask

  task automatic step(input logic [65:0] w, input bit s);
    @(negedge clk);
    compare();
    model(w, s);
    in_word = w;
    in_sof = s;
  endtask

  function automatic logic [65:0] rnd_word();
    logic [1:0] h;
    h = ($urandom % 2 == 0) ? 2'b01 : 2'b10;
    return {$urandom(), $urandom(), h};
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    for (int n = 0; n < FB; n++)
      pn_seq[n] = (n < 58) ? SEED[n] : (pn_seq[n-58] ^ pn_seq[n-39]);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state of the outputs
    checks++;
    if (out_valid !== 1'b0 || out_sof !== 1'b0 || out_word !== '0) begin
      errors++;
      $display("FAIL R1: valid=%0b sof=%0b word=%h expected 0 0 0", out_valid, out_sof, out_word);
    end
    // R8: words before any frame start
    for (int i = 0; i < 6; i++) step(rnd_word(), 0);
    // random frame with marker, then a frame by wrap only (R7)
    for (int i = 0; i < NW; i++) step(rnd_word(), i == 0);
    for (int i = 0; i < NW; i++) step(rnd_word(), 0);
    // all-zero payload, header 01; then all-one payload, header 10 (R2 R4)
    for (int i = 0; i < NW; i++) step({64'h0, 2'b01}, i == 0);
    for (int i = 0; i < NW; i++) step({64'hFFFF_FFFF_FFFF_FFFF, 2'b10}, 0);
    // R9: restart after 10 words of a frame
    for (int i = 0; i < 10; i++) step(rnd_word(), 0);
    for (int i = 0; i < NW; i++) step(rnd_word(), i == 0);
    for (int i = 0; i < NW; i++) step(rnd_word(), 0);
    step(rnd_word(), 1);
    step(rnd_word(), 0);
    @(negedge clk);
    compare();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected end within %0d cycles", WATCHDOG);
      summary();
      $finish;
    end
  end
endmodule